// File: doc/BRIEF.md
# Multi-Channel Edge-Positioned PWM Generator

This block drives up to sixteen pulse-width outputs from one shared time base. A prescale counter divides the input clock into steps, and a step counter runs through one PWM period of steps before it wraps to zero. Every channel has no duty-cycle setting. Instead it holds two step positions: one where its output goes high and one where it goes low. The gap between these positions, measured in shared steps, sets the pulse width.

Software programs the block over a simple write/read bus. Each register occupies a 32-bit word slot, and only bits 7:0 carry data. When the `SHADOW` parameter is set, the timing and edge registers are double-buffered. A write to the sync slot arms a commit, and the shadow contents then move into the working set on the next period boundary. All outputs change their waveform on the same edge, so no output emits a torn period. When `SHADOW` is clear, writes act on the next clock. Channel enables are never buffered.

Top module: `pwm_edge_gen`

## Requirements
- R1: After reset every PWM output is low and every register slot reads 0.
- R2: Byte-address map: prescale at 0x00, period at 0x04, enables of channels 0..7 at 0x08 (bit n is channel n), enables of channels 8..15 at 0x0C (bit n is channel n+8), rising position of channel n at 0x10+8n, falling position at 0x14+8n, and sync at 0xE4. Fields occupy bits 7:0 and read back zero-extended. The sync slot, unmapped or misaligned addresses, and the enable bits and edge slots of channels at or above `NUM_CH` all read 0, and writes to them have no effect.
- R3: The step counter advances once every prescale+1 clocks and wraps from the period value back to 0. One PWM period therefore lasts (prescale+1)·(period+1) clocks, and all channels share it.
- R4: An enabled output goes high on the clock edge where the step counter enters the channel's rising position. It goes low on the edge where the counter enters the falling position, and it holds its level at all other times.
- R5: When a channel's rising and falling positions are equal, the output toggles each time the counter enters that position. The result is high for one full period and low for the next.
- R6: A position above the period value is never reached. With rise at 0 and fall at period+1 the output stays high, and with the two values swapped it stays low.
- R7: Clearing a channel's enable drives its output low from the next clock. Its edge settings are kept and still read back. After re-enabling, the channel starts low.
- R8: With `SHADOW`=0, writes to the prescale, period and edge registers are used from the next clock.
- R9: With `SHADOW`=1, those writes land in shadow registers, and reads return the shadow values. The outputs do not change until a sync write has been followed by a period boundary. The commit takes place on the edge where the step counter wraps to 0, and the step-0 events on that edge already use the new values.
- R10: A commit copies the shadow contents as they stand at the boundary, so shadow writes made after a sync write but before the boundary are included. A sync write on the same edge as a commit stays armed for the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all counters and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the slot at bus_addr |
| bus_addr | input | 8 | Byte address of the register slot |
| bus_wdata | input | 32 | Write data; bits 7:0 are stored |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The hardest situation to reach is a commit that races the software. Here a sync write and later shadow writes fall in the same period, or a sync write lands exactly on a wrap edge. In either case only the exact boundary cycle decides which values a channel starts the new period with. The stimulus reaches the first case on purpose: it aligns itself to a toggling equal-edge channel, which marks a known step mid-period, and then issues the sync and a late edge write before the wrap. Seeded random writes to a short period with prescale 0..3 produce many sync-on-wrap coincidences. A cycle model in the bench follows both a buffered and a direct instance on every clock.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

  localparam int STEP_W = 8;
  localparam int MAX_CH = 16;
  localparam int EDGE_STRIDE = 8;

  typedef logic [STEP_W-1:0] step_t;

  localparam logic [7:0] ADDR_PRESCALE = 8'h00;
  localparam logic [7:0] ADDR_PERIOD   = 8'h04;
  localparam logic [7:0] ADDR_EN_LO    = 8'h08;
  localparam logic [7:0] ADDR_EN_HI    = 8'h0C;
  localparam logic [7:0] ADDR_EDGE0    = 8'h10;
  localparam logic [7:0] ADDR_SYNC     = 8'hE4;

  // Step value the counter holds after this clock.
  function automatic step_t advance_step(step_t cur, step_t last, logic tick);
    if (!tick)
      return cur;
    else if (cur >= last)
      return '0;
    else
      return cur + 1'b1;
  endfunction

  // Output level after the counter enters step 'at'.
  function automatic logic edge_level(logic cur, step_t rise, step_t fall, step_t at);
    if (rise == at && fall == at)
      return !cur;
    else if (rise == at)
      return 1'b1;
    else if (fall == at)
      return 1'b0;
    else
      return cur;
  endfunction

endpackage

// File: rtl/pwm_edge_timebase.sv
module pwm_edge_timebase
  import pwm_edge_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_t prescale,
  input  step_t period,
  output logic  step_tick,
  output logic  period_wrap,
  output step_t step_nxt
);

  step_t pre_q;
  step_t step_q;

  // Comparisons use >= so that a shrinking limit ends the current count.
  assign step_tick   = (pre_q >= prescale);
  assign period_wrap = step_tick && (step_q >= period);
  assign step_nxt    = advance_step(step_q, period, step_tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
    end else begin
      pre_q  <= step_tick ? '0 : pre_q + 1'b1;
      step_q <= step_nxt;
    end
  end

  AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> (pre_q == '0)); // R3
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    period_wrap |=> (step_q == '0)); // R3
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(step_q)); // R3

endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel
  import pwm_edge_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  step_tick,
  input  step_t step_nxt,
  input  step_t rise_pos,
  input  step_t fall_pos,
  output logic  pwm_o
);

  logic lvl_q;
  logic edge_hit;

  assign edge_hit = (rise_pos == step_nxt) || (fall_pos == step_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n)
      lvl_q <= 1'b0;
    else if (!enable)
      lvl_q <= 1'b0;
    else if (step_tick)
      lvl_q <= edge_level(lvl_q, rise_pos, fall_pos, step_nxt);
  end

  assign pwm_o = lvl_q;

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pwm_o); // R7
  AST_EQUAL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step_tick && rise_pos == fall_pos && fall_pos == step_nxt)
      |=> (pwm_o != $past(pwm_o))); // R5
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !(step_tick && edge_hit)) |=> $stable(pwm_o)); // R4
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step_tick && rise_pos == step_nxt && fall_pos != step_nxt) |=> pwm_o); // R4

endmodule

// File: rtl/pwm_edge_regs.sv
module pwm_edge_regs
  import pwm_edge_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter bit SHADOW = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [7:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     period_wrap,
  output step_t                    act_prescale,
  output step_t                    act_period,
  output step_t [NUM_CH-1:0]       eff_rise,
  output step_t [NUM_CH-1:0]       eff_fall,
  output logic  [NUM_CH-1:0]       ch_en
);

  localparam int CH_W = 4;
  localparam logic [8:0] EDGE_END = 9'(16 + EDGE_STRIDE * NUM_CH);

  step_t               shd_prescale;
  step_t               shd_period;
  step_t [NUM_CH-1:0]  shd_rise;
  step_t [NUM_CH-1:0]  shd_fall;
  logic  [NUM_CH-1:0]  en_q;
  logic  [15:0]        en_pad;

  logic       wr_prescale, wr_period, wr_en_lo, wr_en_hi, sync_wr;
  logic       edge_hit, edge_is_fall;
  logic [7:0] edge_off;
  logic [CH_W-1:0] edge_ch;
  step_t      wr_byte;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[31:8];

  assign wr_byte      = bus_wdata[7:0];
  assign wr_prescale  = bus_wr && (bus_addr == ADDR_PRESCALE);
  assign wr_period    = bus_wr && (bus_addr == ADDR_PERIOD);
  assign wr_en_lo     = bus_wr && (bus_addr == ADDR_EN_LO);
  assign wr_en_hi     = bus_wr && (bus_addr == ADDR_EN_HI);
  assign sync_wr      = bus_wr && (bus_addr == ADDR_SYNC);
  assign edge_off     = bus_addr - ADDR_EDGE0;
  assign edge_ch      = edge_off[6:3];
  assign edge_is_fall = bus_addr[2];
  assign edge_hit     = (bus_addr >= ADDR_EDGE0) && ({1'b0, bus_addr} < EDGE_END)
                        && (bus_addr[1:0] == 2'b00);
  assign en_pad       = 16'(en_q);
  assign ch_en        = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_prescale <= '0;
      shd_period   <= '0;
      shd_rise     <= '0;
      shd_fall     <= '0;
      en_q         <= '0;
    end else begin
      if (wr_prescale) shd_prescale <= wr_byte;
      if (wr_period)   shd_period   <= wr_byte;
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_wr && edge_hit && edge_ch == CH_W'(c)) begin
          if (edge_is_fall) shd_fall[c] <= wr_byte;
          else              shd_rise[c] <= wr_byte;
        end
        if (wr_en_lo && c < 8)  en_q[c] <= wr_byte[c % 8];
        if (wr_en_hi && c >= 8) en_q[c] <= wr_byte[c % 8];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_PRESCALE)   bus_rdata[7:0] = shd_prescale;
    else if (bus_addr == ADDR_PERIOD) bus_rdata[7:0] = shd_period;
    else if (bus_addr == ADDR_EN_LO)  bus_rdata[7:0] = en_pad[7:0];
    else if (bus_addr == ADDR_EN_HI)  bus_rdata[7:0] = en_pad[15:8];
    else if (edge_hit) begin
      for (int c = 0; c < NUM_CH; c++)
        if (edge_ch == CH_W'(c))
          bus_rdata[7:0] = edge_is_fall ? shd_fall[c] : shd_rise[c];
    end
  end

  generate
    if (SHADOW) begin : g_shadow
      step_t              act_pre_q;
      step_t              act_per_q;
      step_t [NUM_CH-1:0] act_rise_q;
      step_t [NUM_CH-1:0] act_fall_q;
      logic               pend_q;
      logic               commit;

      assign commit = pend_q && period_wrap;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_pre_q  <= '0;
          act_per_q  <= '0;
          act_rise_q <= '0;
          act_fall_q <= '0;
          pend_q     <= 1'b0;
        end else begin
          if (commit) begin
            act_pre_q  <= shd_prescale;
            act_per_q  <= shd_period;
            act_rise_q <= shd_rise;
            act_fall_q <= shd_fall;
          end
          if (sync_wr)     pend_q <= 1'b1;
          else if (commit) pend_q <= 1'b0;
        end
      end

      assign act_prescale = act_pre_q;
      assign act_period   = act_per_q;
      // The step-0 events on a commit edge already see the committed set.
      assign eff_rise     = commit ? shd_rise : act_rise_q;
      assign eff_fall     = commit ? shd_fall : act_fall_q;

      AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({act_pre_q, act_per_q, act_rise_q, act_fall_q})); // R9
      AST_SYNC_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_wr |=> pend_q); // R10
      AST_COMMIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !sync_wr) |=> !pend_q); // R10
    end else begin : g_direct
      logic unused_direct;
      assign unused_direct = sync_wr ^ period_wrap;
      assign act_prescale  = shd_prescale;
      assign act_period    = shd_period;
      assign eff_rise      = shd_rise;
      assign eff_fall      = shd_fall;
    end
  endgenerate

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_edge_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter bit SHADOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  step_t              act_prescale;
  step_t              act_period;
  step_t [NUM_CH-1:0] eff_rise;
  step_t [NUM_CH-1:0] eff_fall;
  logic  [NUM_CH-1:0] ch_en;
  logic               step_tick;
  logic               period_wrap;
  step_t              step_nxt;

  pwm_edge_regs #(.NUM_CH(NUM_CH), .SHADOW(SHADOW)) i_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .period_wrap  (period_wrap),
    .act_prescale (act_prescale),
    .act_period   (act_period),
    .eff_rise     (eff_rise),
    .eff_fall     (eff_fall),
    .ch_en        (ch_en)
  );

  pwm_edge_timebase i_timebase (
    .clk         (clk),
    .rst_n       (rst_n),
    .prescale    (act_prescale),
    .period      (act_period),
    .step_tick   (step_tick),
    .period_wrap (period_wrap),
    .step_nxt    (step_nxt)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_edge_channel i_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ch_en[c]),
        .step_tick (step_tick),
        .step_nxt  (step_nxt),
        .rise_pos  (eff_rise[c]),
        .fall_pos  (eff_fall[c]),
        .pwm_o     (pwm_out[c])
      );
    end
  endgenerate

endmodule

// File: tb/test_pwm_edge_gen.sv
`timescale 1ns/1ps
module test_pwm_edge_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] rd0, rd1;
  logic [15:0] out0;
  logic [3:0]  out1;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    run_cmp = 1'b0;
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  pwm_edge_gen #(.NUM_CH(16), .SHADOW(1'b1)) i_pwm_edge_gen (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .pwm_out(out0));

  pwm_edge_gen #(.NUM_CH(4), .SHADOW(1'b0)) i_pwm_edge_gen_direct (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .pwm_out(out1));

  // ---------------- cycle model (instance 0 buffered, 1 direct) ----------------
  logic [7:0]  m_apre[2], m_aper[2], m_spre[2], m_sper[2];
  logic [7:0]  m_arise[2][16], m_afall[2][16], m_srise[2][16], m_sfall[2][16];
  logic [15:0] m_en[2], m_lvl[2];
  logic        m_pend[2];
  logic [7:0]  m_pc[2], m_sc[2];

  function automatic int nch(int k);
    return (k == 0) ? 16 : 4;
  endfunction

  function automatic int full_period(int pre, int per);
    return (pre + 1) * (per + 1);
  endfunction

  task automatic model_reset(int k);
    m_apre[k] = 0; m_aper[k] = 0; m_spre[k] = 0; m_sper[k] = 0;
    for (int c = 0; c < 16; c++) begin
      m_arise[k][c] = 0; m_afall[k][c] = 0; m_srise[k][c] = 0; m_sfall[k][c] = 0;
    end
    m_en[k] = 0; m_lvl[k] = 0; m_pend[k] = 0; m_pc[k] = 0; m_sc[k] = 0;
  endtask

  task automatic model_write(int k);
    logic [7:0] d;
    int ch;
    d = bus_wdata[7:0];
    if (bus_addr == 8'h00) m_spre[k] = d;
    else if (bus_addr == 8'h04) m_sper[k] = d;
    else if (bus_addr == 8'h08) begin
      for (int c = 0; c < 8; c++) if (c < nch(k)) m_en[k][c] = d[c];
    end else if (bus_addr == 8'h0C) begin
      for (int c = 8; c < 16; c++) if (c < nch(k)) m_en[k][c] = d[c-8];
    end else if (bus_addr == 8'hE4) begin
      if (k == 0) m_pend[k] = 1'b1;
    end else if (bus_addr >= 8'h10 && int'(bus_addr) < 16 + 8*nch(k) && bus_addr[1:0] == 2'b00) begin
      ch = (int'(bus_addr) - 16) / 8;
      if (bus_addr[2]) m_sfall[k][ch] = d;
      else             m_srise[k][ch] = d;
    end
  endtask

  task automatic model_step(int k);
    logic [7:0] ap, aper, nxt, r, f;
    logic tick, wrap, commit;
    bit sh;
    sh   = (k == 0);
    ap   = sh ? m_apre[k] : m_spre[k];
    aper = sh ? m_aper[k] : m_sper[k];
    tick = (m_pc[k] >= ap);
    wrap = tick && (m_sc[k] >= aper);
    commit = sh && m_pend[k] && wrap;
    if (!tick)     nxt = m_sc[k];
    else if (wrap) nxt = 8'd0;
    else           nxt = m_sc[k] + 8'd1;
    for (int c = 0; c < nch(k); c++) begin
      r = (sh && !commit) ? m_arise[k][c] : m_srise[k][c];
      f = (sh && !commit) ? m_afall[k][c] : m_sfall[k][c];
      if (!m_en[k][c]) m_lvl[k][c] = 1'b0;
      else if (tick) begin
        if (r == nxt && f == nxt) m_lvl[k][c] = !m_lvl[k][c];
        else if (r == nxt)        m_lvl[k][c] = 1'b1;
        else if (f == nxt)        m_lvl[k][c] = 1'b0;
      end
    end
    m_pc[k] = tick ? 8'd0 : m_pc[k] + 8'd1;
    m_sc[k] = nxt;
    if (commit) begin
      m_apre[k] = m_spre[k]; m_aper[k] = m_sper[k];
      for (int c = 0; c < 16; c++) begin
        m_arise[k][c] = m_srise[k][c]; m_afall[k][c] = m_sfall[k][c];
      end
      m_pend[k] = 1'b0;
    end
    if (bus_wr) model_write(k);
  endtask

  function automatic logic [31:0] exp_rd(int k, logic [7:0] a);
    int ch;
    if (a == 8'h00) return {24'h0, m_spre[k]};
    if (a == 8'h04) return {24'h0, m_sper[k]};
    if (a == 8'h08) return {24'h0, m_en[k][7:0]};
    if (a == 8'h0C) return {24'h0, m_en[k][15:8]};
    if (a >= 8'h10 && int'(a) < 16 + 8*nch(k) && a[1:0] == 2'b00) begin
      ch = (int'(a) - 16) / 8;
      return {24'h0, a[2] ? m_sfall[k][ch] : m_srise[k][ch]};
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) model_reset(k);
      else        model_step(k);
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp && !finished) begin
      check(out0 == m_lvl[0], cur_req, "buffered outputs vs model", 32'(out0), 32'(m_lvl[0]));
      check(out1 == m_lvl[1][3:0], cur_req, "direct outputs vs model", 32'(out1), 32'(m_lvl[1][3:0]));
    end
  end

  function automatic logic get_bit(int k, int c);
    return (k == 0) ? out0[c] : out1[c];
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(logic [7:0] a, logic [31:0] e0, logic [31:0] e1, string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(rd0 == e0, req, $sformatf("buffered read @%h", a), rd0, e0);
    check(rd1 == e1, req, $sformatf("direct read @%h", a), rd1, e1);
  endtask

  task automatic wait_rise(int k, int c);
    logic prev;
    prev = get_bit(k, c);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!prev && get_bit(k, c)) return;
      prev = get_bit(k, c);
    end
  endtask

  task automatic wait_change(int k, int c);
    logic prev;
    prev = get_bit(k, c);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (prev != get_bit(k, c)) return;
    end
  endtask

  task automatic measure_high(int k, int c, output int n);
    wait_rise(k, c);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (get_bit(k, c) && n < 5000);
  endtask

  task automatic measure_gap(int k, int c, output int n);
    logic prev;
    wait_rise(k, c);
    n = 0;
    prev = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (!prev && get_bit(k, c)) break;
      prev = get_bit(k, c);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    bit ok2, ok3;
    logic [7:0] a;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmp = 1'b1;

    // R1: reset state
    cur_req = "R1";
    check(out0 == 16'h0 && out1 == 4'h0, "R1", "outputs after reset", {out0, 12'h0, out1}, 32'h0);
    rd_check(8'h00, 0, 0, "R1");
    rd_check(8'h08, 0, 0, "R1");
    rd_check(8'h14, 0, 0, "R1");

    // R2: map and readback
    cur_req = "R2";
    wr(8'h00, 32'h1234_5603);
    wr(8'h04, 32'd9);
    wr(8'h10, 2);  wr(8'h14, 6);
    wr(8'h18, 4);  wr(8'h1C, 4);
    wr(8'h20, 0);  wr(8'h24, 10);
    wr(8'h28, 10); wr(8'h2C, 0);
    wr(8'h38, 7);
    wr(8'h08, 32'h0F);
    wr(8'h0C, 32'h81);
    rd_check(8'h00, 3, 3, "R2");
    rd_check(8'h04, 9, 9, "R2");
    rd_check(8'h38, 7, 0, "R2");
    rd_check(8'h0C, 32'h81, 0, "R2");
    rd_check(8'h08, 32'h0F, 32'h0F, "R2");
    rd_check(8'hE4, 0, 0, "R2");
    rd_check(8'hE8, 0, 0, "R2");
    rd_check(8'h12, 0, 0, "R2");

    // commit buffered set
    wr(8'hE4, 1);
    repeat (100) @(negedge clk);

    cur_req = "R3";
    measure_gap(0, 0, n);
    check(n == full_period(3, 9), "R3", "buffered period clocks", n, full_period(3, 9));
    measure_gap(1, 0, n);
    check(n == full_period(3, 9), "R3", "direct period clocks", n, full_period(3, 9));

    cur_req = "R4";
    measure_high(0, 0, n);
    check(n == (6 - 2) * 4, "R4", "high time rise2 fall6", n, 16);
    measure_high(1, 0, n);
    check(n == (6 - 2) * 4, "R4", "direct high time rise2 fall6", n, 16);

    cur_req = "R5";
    measure_high(0, 1, n);
    check(n == full_period(3, 9), "R5", "equal-edge high time", n, 40);
    measure_high(1, 1, n);
    check(n == full_period(3, 9), "R5", "direct equal-edge high time", n, 40);

    cur_req = "R6";
    ok2 = 1'b1; ok3 = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!(out0[2] && out1[2])) ok2 = 1'b0;
      if (out0[3] || out1[3]) ok3 = 1'b0;
    end
    check(ok2, "R6", "rise0/fall above period stays high", ok2, 1);
    check(ok3, "R6", "swapped stays low", ok3, 1);

    cur_req = "R7";
    wr(8'h08, 32'h0E);
    ok2 = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (out0[0] || out1[0]) ok2 = 1'b0;
    end
    check(ok2, "R7", "disabled channel low", ok2, 1);
    rd_check(8'h10, 2, 2, "R7");
    rd_check(8'h14, 6, 6, "R7");
    wr(8'h08, 32'h0F);

    cur_req = "R9";
    wr(8'h10, 5); wr(8'h14, 7);
    rd_check(8'h10, 5, 5, "R9");
    measure_high(0, 0, n);
    check(n == 16, "R9", "buffered keeps old edges before sync", n, 16);
    cur_req = "R8";
    measure_high(1, 0, n);
    check(n == (7 - 5) * 4, "R8", "direct uses new edges at once", n, 8);
    cur_req = "R9";
    wr(8'hE4, 1);
    repeat (80) @(negedge clk);
    measure_high(0, 0, n);
    check(n == (7 - 5) * 4, "R9", "buffered new edges after commit", n, 8);

    cur_req = "R10";
    wait_change(0, 1);
    wr(8'hE4, 1);
    wr(8'h14, 9);
    repeat (80) @(negedge clk);
    measure_high(0, 0, n);
    check(n == (9 - 5) * 4, "R10", "late shadow write included", n, 16);

    // random phase against the cycle model
    cur_req = "R4";
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 9))
        0: wr(8'h00, $urandom_range(0, 3));
        1: wr(8'h04, $urandom_range(0, 11));
        2, 3, 4, 5: wr(8'(16 + 8 * $urandom_range(0, 15) + 4 * $urandom_range(0, 1)),
                       $urandom_range(0, 13));
        6: wr(8'h08, $urandom);
        7: wr(8'h0C, $urandom);
        8: wr(8'hE4, 1);
        default: begin
          a = 8'(4 * $urandom_range(0, 63));
          rd_check(a, exp_rd(0, a), exp_rd(1, a), "R2");
        end
      endcase
      repeat ($urandom_range(0, 40)) @(negedge clk);
    end

    run_cmp = 1'b0;
    finish_run();
  end

endmodule